// File: doc/BRIEF.md
# Exponent and Fraction Gain Stage with Staged Settings

This block sits behind a decimating low-pass filter and scales each complex sample by a power-of-two exponent combined with a fractional mantissa. The mantissa is an 8-bit fraction F, so the multiplier is (1 + F/256). The effective shift is the programmed exponent S minus a base shift B. B follows the decimation setting, so the same S and F produce the same overall gain whichever decimation is in use. Each lane rounds symmetrically and saturates to a signed 16-bit result. When either lane clips, the block raises a one-cycle overflow pulse.

Software writes the fraction first and then the exponent. Both land in staging registers. The exponent write carries a mode bit that selects when the staged pair becomes live:
- Mode bit 0: the pair goes live at once.
- Mode bit 1: the pair is held until the next falling edge on an active-low gain sync line, so that several blocks can change gain in the same cycle.

A live setting never changes in the middle of a sample. I and Q are always scaled by the same pair.

Top module: `gain_stage_top`

## Requirements
- R1: For a valid input sample x (24-bit two's complement on each lane), each output equals x·(256+F)·2^S / 2^(4+B). The division rounds to the nearest integer, and the result saturates to 16-bit two's complement.
- R2: The decimation code c selects the base shift as B = 6 − c for c = 0..6, which means decimation 2^c. Code 7 behaves as code 6 (B = 0).
- R3: At unity setting (S = B, F = 0), an input holding a 12-bit signed value v appears as v·16 on the 16-bit output. The value therefore fills the upper 12 bits and the lower 4 bits are zero.
- R4: A fraction write on its own does not change the gain applied to samples. The new fraction applies only after a later exponent write commits it.
- R5: An exponent write with the mode bit at 0 commits the staged fraction and exponent in its own cycle.
- R6: An exponent write with the mode bit at 1 stages the pair. The pair goes live on the first cycle afterwards in which the gain sync input is low after having been high. A sync fall with no exponent write pending leaves the gain unchanged.
- R7: A result above 32767 gives 0x7FFF, and a result below −32768 gives 0x8000. The overflow pulse is high in the same cycle as that output.
- R8: Rounding is symmetric: an exact half rounds away from zero (+0.5 → 1, −0.5 → −1, +1.5 → 2, −1.5 → −2).
- R9: out_valid is high exactly one cycle after in_valid. While in_valid is low, out_i and out_q hold their last values and the overflow pulse is low.
- R10: A sample accepted in the same cycle as a committing write uses the old setting. The next sample uses the new one.
- R11: After reset, the live and staged settings are S = 6, F = 0 and mode bit 0. The outputs, out_valid and the overflow pulse are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frac_wr | input | 1 | Write strobe for the staged fraction |
| frac_wdata | input | 8 | Fraction value F |
| exp_wr | input | 1 | Write strobe for the staged exponent and mode bit |
| exp_wdata | input | 4 | Exponent value S |
| exp_sync_mode | input | 1 | Mode bit written with the exponent: 0 commits at once, 1 waits for the sync fall |
| gsync_n | input | 1 | Active-low gain sync line |
| dec_code | input | 3 | Decimation code c, which selects the base shift |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 24 | In-phase input sample |
| in_q | input | 24 | Quadrature input sample |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 16 | Scaled in-phase output |
| out_q | output | 16 | Scaled quadrature output |
| ovf_pulse | output | 1 | One-cycle overflow flag for the sample on the outputs |

## Verification
Wrong staged or live state in this block shows up as a wrong output magnitude on the very next valid sample after the faulty commit or missed commit. The bench therefore follows every write and every sync pulse with a sample whose expected value separates the old gain from the new one. A wrong rounding or saturation path shows up in the same cycle as the affected sample. For that reason, exact-half inputs and near-full-scale inputs are driven directly and scored one cycle after acceptance. Randomised settings across all decimation codes compare both lanes against a model of the gain formula that the bench computes on its own.

// File: rtl/gain_stage_pkg.sv
package gain_stage_pkg;

   // Source of a setting commit in a given cycle.
   typedef enum logic [1:0] {
      CMT_NONE  = 2'd0,
      CMT_WRITE = 2'd1,
      CMT_SYNC  = 2'd2
   } commit_e;

   // Number of sample lanes handled in parallel (I and Q).
   localparam int unsigned LANES = 2;

endpackage

// File: rtl/gain_cfg_bank.sv
module gain_cfg_bank
   import gain_stage_pkg::*;
#(
   parameter int unsigned FRAC_W    = 8,
   parameter int unsigned EXP_W     = 4,
   parameter int unsigned RESET_EXP = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frac_wr,
   input  logic [FRAC_W-1:0] frac_wdata,
   input  logic              exp_wr,
   input  logic [EXP_W-1:0]  exp_wdata,
   input  logic              exp_sync_mode,
   input  logic              gsync_n,
   output logic [FRAC_W-1:0] act_frac,
   output logic [EXP_W-1:0]  act_exp,
   output commit_e           commit_src
);

   localparam logic [EXP_W-1:0] EXP_RST = EXP_W'(RESET_EXP);

   if (RESET_EXP >= (1 << EXP_W)) begin : g_bad_reset_exp
      $error("gain_cfg_bank: RESET_EXP does not fit in EXP_W bits");
   end

   logic [FRAC_W-1:0] stg_frac;
   logic [EXP_W-1:0]  stg_exp;
   logic              stg_mode;
   logic              stg_pending;
   logic              gsync_q;
   logic              sync_fall;
   logic [FRAC_W-1:0] frac_for_write;

   // Sync line edge detection: a fall is a high-to-low transition.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gsync_q <= 1'b1;
      else        gsync_q <= gsync_n;
   end

   assign sync_fall = gsync_q & ~gsync_n;

   // A fraction written in the same cycle as a committing exponent write
   // belongs to that commit.
   assign frac_for_write = frac_wr ? frac_wdata : stg_frac;

   always_comb begin
      commit_src = CMT_NONE;
      if (exp_wr) begin
         if (!exp_sync_mode) commit_src = CMT_WRITE;
      end else if (stg_mode && stg_pending && sync_fall) begin
         commit_src = CMT_SYNC;
      end
   end

   // Staging registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_frac    <= '0;
         stg_exp     <= EXP_RST;
         stg_mode    <= 1'b0;
         stg_pending <= 1'b0;
      end else begin
         if (frac_wr) stg_frac <= frac_wdata;
         if (exp_wr) begin
            stg_exp     <= exp_wdata;
            stg_mode    <= exp_sync_mode;
            stg_pending <= exp_sync_mode;
         end else if (commit_src == CMT_SYNC) begin
            stg_pending <= 1'b0;
         end
      end
   end

   // Live registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_frac <= '0;
         act_exp  <= EXP_RST;
      end else begin
         unique case (commit_src)
            CMT_WRITE: begin
               act_frac <= frac_for_write;
               act_exp  <= exp_wdata;
            end
            CMT_SYNC: begin
               act_frac <= stg_frac;
               act_exp  <= stg_exp;
            end
            default: ;
         endcase
      end
   end

   // R4 / R6: the live pair only moves in a commit cycle.
   assert_live_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_src == CMT_NONE) |=> ($stable(act_frac) && $stable(act_exp)));

   // R5: an immediate-mode exponent write is live in the next cycle.
   assert_write_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_wr && !exp_sync_mode) |=> (act_exp == $past(exp_wdata)));

   // R6: a staged write waits for the sync line.
   assert_staged_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_wr && exp_sync_mode) |=> $stable(act_exp));

endmodule

// File: rtl/gain_lane.sv
module gain_lane #(
   parameter int unsigned IN_W   = 24,
   parameter int unsigned OUT_W  = 16,
   parameter int unsigned FRAC_W = 8,
   parameter int unsigned EXP_W  = 4,
   parameter int unsigned B_W    = 3,
   parameter int unsigned R_BASE = 4,
   parameter int unsigned B_MAX  = 6
) (
   input  logic [IN_W-1:0]   sample,
   input  logic [FRAC_W-1:0] frac,
   input  logic [EXP_W-1:0]  expo,
   input  logic [B_W-1:0]    bshift,
   output logic [OUT_W-1:0]  result,
   output logic              sat
);

   // The multiplier (2^FRAC_W + F) needs FRAC_W+1 magnitude bits plus a sign.
   localparam int unsigned MUL_W = IN_W + FRAC_W + 2;
   localparam int unsigned EXP_MAX = (1 << EXP_W) - 1;
   localparam int unsigned SUM_W = MUL_W + EXP_MAX + 1;
   localparam int unsigned SH_W  = $clog2(R_BASE + B_MAX + 1) + 1;

   if (OUT_W < 2 || OUT_W >= SUM_W) begin : g_bad_out_w
      $error("gain_lane: OUT_W out of range");
   end

   logic signed [MUL_W-1:0] x_ext;
   logic signed [MUL_W-1:0] k_ext;
   logic signed [MUL_W-1:0] prod;
   logic signed [SUM_W-1:0] wide;
   logic signed [SUM_W-1:0] wide_sh;
   logic signed [SUM_W-1:0] half;
   logic signed [SUM_W-1:0] neg_adj;
   logic signed [SUM_W-1:0] rnd;
   logic [SH_W-1:0]         rsh;
   logic                    pos_ovf;
   logic                    neg_ovf;

   // Mantissa multiply: sample times (2^FRAC_W + F).
   always_comb begin
      x_ext = {{(MUL_W-IN_W){sample[IN_W-1]}}, sample};
      k_ext = {{(MUL_W-FRAC_W-1){1'b0}}, 1'b1, frac};
      prod  = x_ext * k_ext;
   end

   // Exponent shift up, then rounded shift down by the base amount.
   always_comb begin
      wide    = {{(SUM_W-MUL_W){prod[MUL_W-1]}}, prod};
      wide_sh = wide <<< expo;
      rsh     = SH_W'(R_BASE) + SH_W'(bshift);
      half    = SUM_W'(1) << (rsh - SH_W'(1));
      neg_adj = {{(SUM_W-1){1'b0}}, wide_sh[SUM_W-1]};
      rnd     = (wide_sh + half - neg_adj) >>> rsh;
   end

   // Saturation to the output width.
   always_comb begin
      pos_ovf = !rnd[SUM_W-1] && (|rnd[SUM_W-2:OUT_W-1]);
      neg_ovf = rnd[SUM_W-1] && !(&rnd[SUM_W-2:OUT_W-1]);
      sat     = pos_ovf | neg_ovf;
      if (pos_ovf)      result = {1'b0, {(OUT_W-1){1'b1}}};
      else if (neg_ovf) result = {1'b1, {(OUT_W-1){1'b0}}};
      else              result = rnd[OUT_W-1:0];
   end

endmodule

// File: rtl/gain_stage_top.sv
module gain_stage_top
   import gain_stage_pkg::*;
#(
   parameter int unsigned IN_W      = 24,
   parameter int unsigned OUT_W     = 16,
   parameter int unsigned FRAC_W    = 8,
   parameter int unsigned EXP_W     = 4,
   parameter int unsigned DEC_W     = 3,
   parameter int unsigned B_MAX     = 6,
   parameter int unsigned SCALE_W   = 12,
   parameter int unsigned RESET_EXP = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frac_wr,
   input  logic [7:0]        frac_wdata,
   input  logic              exp_wr,
   input  logic [3:0]        exp_wdata,
   input  logic              exp_sync_mode,
   input  logic              gsync_n,
   input  logic [2:0]        dec_code,
   input  logic              in_valid,
   input  logic [23:0]       in_i,
   input  logic [23:0]       in_q,
   output logic              out_valid,
   output logic [15:0]       out_i,
   output logic [15:0]       out_q,
   output logic              ovf_pulse
);

   localparam int unsigned R_BASE = FRAC_W - (OUT_W - SCALE_W);
   localparam int unsigned B_W    = $clog2(B_MAX + 1);

   if (IN_W != 24 || OUT_W != 16 || FRAC_W != 8 || EXP_W != 4 || DEC_W != 3) begin : g_bad_port_w
      $error("gain_stage_top: port widths are fixed at 24/16/8/4/3");
   end
   if (OUT_W <= SCALE_W || R_BASE < 1) begin : g_bad_scale
      $error("gain_stage_top: SCALE_W leaves no rounding position");
   end
   if ((1 << DEC_W) <= B_MAX) begin : g_bad_dec_w
      $error("gain_stage_top: DEC_W cannot encode B_MAX");
   end

   logic [FRAC_W-1:0] act_frac;
   logic [EXP_W-1:0]  act_exp;
   commit_e           commit_src;
   logic [B_W-1:0]    bshift;

   logic [IN_W-1:0]  lane_in  [LANES];
   logic [OUT_W-1:0] lane_out [LANES];
   logic [LANES-1:0] lane_sat;

   gain_cfg_bank #(
      .FRAC_W    (FRAC_W),
      .EXP_W     (EXP_W),
      .RESET_EXP (RESET_EXP)
   ) u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .frac_wr       (frac_wr),
      .frac_wdata    (frac_wdata),
      .exp_wr        (exp_wr),
      .exp_wdata     (exp_wdata),
      .exp_sync_mode (exp_sync_mode),
      .gsync_n       (gsync_n),
      .act_frac      (act_frac),
      .act_exp       (act_exp),
      .commit_src    (commit_src)
   );

   // Base shift from the decimation code; codes above B_MAX clamp to zero.
   always_comb begin
      if (dec_code >= DEC_W'(B_MAX)) bshift = '0;
      else                           bshift = B_W'(B_MAX) - B_W'(dec_code);
   end

   assign lane_in[0] = in_i;
   assign lane_in[1] = in_q;

   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      gain_lane #(
         .IN_W   (IN_W),
         .OUT_W  (OUT_W),
         .FRAC_W (FRAC_W),
         .EXP_W  (EXP_W),
         .B_W    (B_W),
         .R_BASE (R_BASE),
         .B_MAX  (B_MAX)
      ) u_lane (
         .sample (lane_in[ln]),
         .frac   (act_frac),
         .expo   (act_exp),
         .bshift (bshift),
         .result (lane_out[ln]),
         .sat    (lane_sat[ln])
      );
   end

   // Output register stage.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_i     <= '0;
         out_q     <= '0;
         ovf_pulse <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_i     <= lane_out[0];
            out_q     <= lane_out[1];
            ovf_pulse <= |lane_sat;
         end else begin
            ovf_pulse <= 1'b0;
         end
      end
   end

   localparam logic [15:0] FS_POS = 16'h7FFF;
   localparam logic [15:0] FS_NEG = 16'h8000;

   // R9: one-cycle latency on the qualifier.
   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !ovf_pulse));
   assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_i) && $stable(out_q)));

   // R7: an overflow flag always comes with a full-scale lane.
   assert_ovf_fullscale_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_pulse |-> (out_valid && (out_i == FS_POS || out_i == FS_NEG ||
                                   out_q == FS_POS || out_q == FS_NEG)));

endmodule

// File: tb/gain_stage_top_bench.sv
`timescale 1ns/1ps
module gain_stage_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frac_wr = 1'b0;
   logic [7:0]  frac_wdata = '0;
   logic        exp_wr = 1'b0;
   logic [3:0]  exp_wdata = '0;
   logic        exp_sync_mode = 1'b0;
   logic        gsync_n = 1'b1;
   logic [2:0]  dec_code = '0;
   logic        in_valid = 1'b0;
   logic [23:0] in_i = '0;
   logic [23:0] in_q = '0;
   logic        out_valid;
   logic [15:0] out_i;
   logic [15:0] out_q;
   logic        ovf_pulse;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Bench copy of the live setting.
   int m_f = 0;
   int m_s = 6;

   always #4 clk = ~clk;

   gain_stage_top u_gain_stage_top (
      .clk           (clk),
      .rst_n         (rst_n),
      .frac_wr       (frac_wr),
      .frac_wdata    (frac_wdata),
      .exp_wr        (exp_wr),
      .exp_wdata     (exp_wdata),
      .exp_sync_mode (exp_sync_mode),
      .gsync_n       (gsync_n),
      .dec_code      (dec_code),
      .in_valid      (in_valid),
      .in_i          (in_i),
      .in_q          (in_q),
      .out_valid     (out_valid),
      .out_i         (out_i),
      .out_q         (out_q),
      .ovf_pulse     (ovf_pulse)
   );

   function automatic longint model_raw(longint x, int f, int s, int code);
      int b;
      int r;
      longint v;
      longint h;
      b = (code > 6) ? 0 : 6 - code;
      r = 4 + b;
      v = x * longint'(256 + f) * (longint'(1) <<< s);
      h = longint'(1) <<< (r - 1);
      if (v >= 0) return (v + h) / (longint'(1) <<< r);
      else        return -((-v + h) / (longint'(1) <<< r));
   endfunction

   function automatic longint model_sat(longint v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   function automatic bit model_ovf(longint v);
      return (v > 32767) || (v < -32768);
   endfunction

   task automatic chk(string tag, longint act, longint expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   task automatic write_frac(int f);
      @(negedge clk);
      frac_wr = 1'b1; frac_wdata = 8'(f);
      @(negedge clk);
      frac_wr = 1'b0;
   endtask

   task automatic write_exp(int s, bit mode);
      @(negedge clk);
      exp_wr = 1'b1; exp_wdata = 4'(s); exp_sync_mode = mode;
      @(negedge clk);
      exp_wr = 1'b0;
   endtask

   task automatic sync_pulse();
      @(negedge clk);
      gsync_n = 1'b0;
      @(negedge clk);
      gsync_n = 1'b1;
   endtask

   // Drive one sample, then score it one cycle later.
   task automatic send_check(string tag, longint xi, longint xq);
      longint ri;
      longint rq;
      @(negedge clk);
      in_valid = 1'b1; in_i = 24'(xi); in_q = 24'(xq);
      @(negedge clk);
      in_valid = 1'b0;
      ri = model_raw(xi, m_f, m_s, int'(dec_code));
      rq = model_raw(xq, m_f, m_s, int'(dec_code));
      chk({tag, " valid"}, longint'(out_valid), 1);
      chk({tag, " I"}, longint'($signed(out_i)), model_sat(ri));
      chk({tag, " Q"}, longint'($signed(out_q)), model_sat(rq));
      chk({tag, " ovf"}, longint'(ovf_pulse), longint'(model_ovf(ri) || model_ovf(rq)));
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      longint prev_i;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R11: reset state.
      chk("R11 out_valid", longint'(out_valid), 0);
      chk("R11 out_i", longint'(out_i), 0);
      chk("R11 ovf", longint'(ovf_pulse), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R11: reset gain is S=6, F=0 -> unity at code 0.
      dec_code = 3'd0;
      send_check("R11 reset gain", 1000, -1000);
      chk("R11 reset unity I", longint'($signed(out_i)), 16000);

      // R3 / R2: unity for every decimation code.
      for (int c = 0; c <= 6; c++) begin
         dec_code = 3'(c);
         write_exp(6 - c, 1'b0); m_s = 6 - c; m_f = 0;
         send_check("R3 unity", 2047, -2048);
         chk("R3 unity max I", longint'(out_i), 32'h7FF0);
         chk("R3 unity min Q", longint'(out_q), 32'h8000);
      end
      // R2: code 7 behaves as code 6.
      dec_code = 3'd7;
      send_check("R2 code7", 1234, -77);
      chk("R2 code7 I", longint'($signed(out_i)), 1234 * 16);

      // R8: symmetric rounding at exact halves (code 0, S=0 -> x/4).
      dec_code = 3'd0;
      write_exp(0, 1'b0); m_s = 0;
      send_check("R8 half", 2, -2);
      chk("R8 +0.5", longint'($signed(out_i)), 1);
      chk("R8 -0.5", longint'($signed(out_q)), -1);
      send_check("R8 threehalf", 6, -6);
      chk("R8 +1.5", longint'($signed(out_i)), 2);
      chk("R8 -1.5", longint'($signed(out_q)), -2);
      send_check("R8 quarter", 1, -3);

      // R4: fraction write alone has no effect.
      write_exp(6, 1'b0); m_s = 6;
      write_frac(128);
      send_check("R4 frac only", 1000, 500);
      chk("R4 frac only I", longint'($signed(out_i)), 16000);
      // R5: exponent write commits the staged fraction.
      write_exp(6, 1'b0); m_f = 128;
      send_check("R5 commit", 1000, 500);
      chk("R5 commit I", longint'($signed(out_i)), 24000);

      // R6: staged mode waits for the sync fall.
      write_frac(0);
      write_exp(5, 1'b1);
      send_check("R6 staged wait", 1000, -1000);
      chk("R6 staged wait I", longint'($signed(out_i)), 24000);
      sync_pulse(); m_f = 0; m_s = 5;
      send_check("R6 after sync", 1000, -1000);
      chk("R6 after sync I", longint'($signed(out_i)), 8000);
      // R6: sync fall with nothing pending leaves the gain alone.
      write_frac(255);
      sync_pulse();
      send_check("R6 idle sync", 1000, -1000);
      chk("R6 idle sync I", longint'($signed(out_i)), 8000);

      // R10: sample in the commit cycle uses old gain, next uses new.
      @(negedge clk);
      in_valid = 1'b1; in_i = 24'(1000); in_q = 24'(0);
      exp_wr = 1'b1; exp_wdata = 4'd6; exp_sync_mode = 1'b0;
      @(negedge clk);
      exp_wr = 1'b0;
      in_i = 24'(1000);
      chk("R10 old gain", longint'($signed(out_i)), 8000);
      @(negedge clk);
      in_valid = 1'b0;
      m_f = 255; m_s = 6;
      chk("R10 new gain", longint'($signed(out_i)), model_sat(model_raw(1000, 255, 6, 0)));

      // R9: idle cycles hold data and drop valid.
      prev_i = longint'(out_i);
      @(negedge clk);
      chk("R9 idle valid", longint'(out_valid), 0);
      chk("R9 idle hold", longint'(out_i), prev_i);

      // R7: saturation both ways, Q-only overflow too.
      dec_code = 3'd6;
      write_frac(0);
      write_exp(15, 1'b0); m_f = 0; m_s = 15;
      send_check("R7 sat", 8388607, -8388608);
      chk("R7 pos fs", longint'(out_i), 32'h7FFF);
      chk("R7 neg fs", longint'(out_q), 32'h8000);
      chk("R7 ovf", longint'(ovf_pulse), 1);
      send_check("R7 q only", 0, 1);
      chk("R7 q only ovf", longint'(ovf_pulse), 1);
      send_check("R7 no ovf", 0, 0);
      chk("R7 no ovf flag", longint'(ovf_pulse), 0);

      // R1: random settings across all codes.
      for (int n = 0; n < 300; n++) begin
         int f;
         int s;
         longint xi;
         longint xq;
         f = int'($urandom_range(255, 0));
         s = int'($urandom_range(15, 0));
         dec_code = 3'($urandom_range(7, 0));
         write_frac(f);
         write_exp(s, 1'b0); m_f = f; m_s = s;
         for (int k = 0; k < 3; k++) begin
            if ($urandom_range(1, 0) == 1) begin
               xi = longint'($signed(24'($urandom())));
               xq = longint'($signed(24'($urandom())));
            end else begin
               xi = longint'($signed(12'($urandom())));
               xq = longint'($signed(12'($urandom())));
            end
            send_check("R1 random", xi, xq);
         end
      end

      done = 1;
      finish_run();
   end

endmodule